// File: doc/BRIEF.md
# Transmit Descriptor Ring Controller

This block is the sequencing core of a transmit DMA engine that works through a ring of descriptors in host memory. Once started, it asks for the descriptor at its current ring position. If the descriptor is handed to the DMA, the block requests as many data beats as the descriptor's length gives, moving them from the host buffer into the transmit FIFO. It then waits for the transmitter to report status, writes the descriptor back, and moves on to the next ring slot. The ring index wraps after the last slot.

A descriptor that the DMA does not own parks the engine in a Suspended state. A FIFO underflow while a frame is in flight does the same. Software resumes a suspended engine with a poll pulse. That pulse re-fetches the same ring slot. A stop request never cuts a descriptor in half. It is remembered, and it takes effect when the current descriptor has been closed, or at once if the engine is suspended. The current state is exported as a fixed 3-bit code that software can read.

Top module: `tx_desc_fsm`

## Requirements
- R1: After reset the state code is 000 (Stopped) and the ring index is 0. `desc_req_o`, `mv_req_o` and `wb_strobe_o` are all low.
- R2: `state_o` only ever takes the codes 000, 001, 010, 011, 110 and 111. `desc_req_o` is high exactly in 001 (fetch), `mv_req_o` exactly in 011 (read data) and `wb_strobe_o` exactly in 111 (close).
- R3: In 000, a `start_i` pulse without `stop_i` moves the state to 001 at the next edge and resets the ring index to 0. `start_i` has no effect in any other state.
- R4: In 001, a `desc_rsp_valid_i` with `desc_rsp_own_i`=1 leads to 011 if `desc_rsp_len_i` is nonzero, or straight to 010 if it is zero. With `desc_rsp_own_i`=0 it leads to 110. A response outside 001 has no effect.
- R5: In 011, each `mv_ack_i` consumes one beat. The edge that accepts the last of the `desc_rsp_len_i` beats moves the state to 010.
- R6: In 010, `tx_status_i` moves the state to 111. State 111 lasts exactly one cycle, and on leaving it the ring index advances by one, wrapping from RING_DEPTH-1 to 0.
- R7: `underflow_i` in 011 or 010 moves the state to 110 at the next edge. It wins over a last beat or a status arriving in the same cycle, and it leaves the ring index unchanged.
- R8: In 110, `poll_i` moves the state to 001 with the same ring index. `poll_i` has no effect in any other state.
- R9: A `stop_i` pulse in 001, 011 or 010 is held pending. When 111 is left, a pending stop or a `stop_i` in that cycle leads to 000 instead of 001. In 110, a pending stop or `stop_i` leads to 000 at the next edge and takes priority over `poll_i`. In 000, `stop_i` wins over `start_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command pulse |
| stop_i | input | 1 | Stop command pulse |
| desc_rsp_valid_i | input | 1 | Descriptor fetch response valid |
| desc_rsp_own_i | input | 1 | Ownership of fetched descriptor, 1 = DMA owns it |
| desc_rsp_len_i | input | LEN_W (12) | Data beats described by the fetched descriptor |
| mv_ack_i | input | 1 | One data beat accepted into the FIFO |
| underflow_i | input | 1 | Transmit FIFO underflow |
| tx_status_i | input | 1 | Transmit status for the current frame is ready |
| poll_i | input | 1 | Poll demand, resumes a suspended engine |
| desc_req_o | output | 1 | Descriptor fetch request |
| mv_req_o | output | 1 | Data move request |
| wb_strobe_o | output | 1 | Descriptor writeback strobe |
| desc_idx_o | output | IDX_W (3) | Current ring slot |
| state_o | output | 3 | Software-visible state code |

## Verification
Two functions compete in single cycles. The first pair is the last data beat, or the transmit status, against an underflow. The second pair is a stop request against the close of a descriptor or against a poll demand. Directed sequences put an acknowledge and an underflow in one cycle, and a stop in the very cycle of the writeback strobe and of a poll. The random phase raises underflow, stop and poll at low rates across every state, so these pairings also occur by chance. A bench model applies the stated priorities, and every cycle it compares the predicted state code, ring index and strobes against the ports.

// File: rtl/txd_pkg.sv
package txd_pkg;

    typedef enum logic [2:0] {
        ST_STOP  = 3'b000,
        ST_FETCH = 3'b001,
        ST_WAIT  = 3'b010,
        ST_READ  = 3'b011,
        ST_SUSP  = 3'b110,
        ST_CLOSE = 3'b111
    } txd_state_e;

    typedef struct packed {
        txd_state_e st;
        logic       stop_pend;
    } txd_ctrl_s;

endpackage

// File: rtl/txd_beat_cnt.sv
module txd_beat_cnt #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             dec_i,
    output logic             last_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = len_i;
        else if (dec_i)
            cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == ONE);

    AST_NO_BEAT_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> cnt_q != '0); // R5

endmodule

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
    parameter int DEPTH = 8,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clr_i)
            idx_d = '0;
        else if (adv_i)
            idx_d = (idx_q == LAST) ? '0 : idx_q + IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx_o = idx_q;

    AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST); // R6

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i && idx_q == LAST) |=> idx_q == '0); // R6

endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
    import txd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       rsp_valid_i,
    input  logic       rsp_own_i,
    input  logic       len_zero_i,
    input  logic       mv_ack_i,
    input  logic       last_beat_i,
    input  logic       underflow_i,
    input  logic       status_i,
    input  logic       poll_i,
    output txd_state_e st_o,
    output logic       cnt_load_o,
    output logic       cnt_dec_o,
    output logic       idx_clr_o,
    output logic       idx_adv_o
);
    txd_ctrl_s c_d, c_q;
    logic      stop_now;

    assign stop_now = c_q.stop_pend || stop_i;

    always_comb begin
        c_d        = c_q;
        cnt_load_o = 1'b0;
        cnt_dec_o  = 1'b0;
        idx_clr_o  = 1'b0;
        idx_adv_o  = 1'b0;
        unique case (c_q.st)
            ST_STOP: begin
                c_d.stop_pend = 1'b0;
                if (start_i && !stop_i) begin
                    c_d.st    = ST_FETCH;
                    idx_clr_o = 1'b1;
                end
            end
            ST_FETCH: begin
                c_d.stop_pend = stop_now;
                if (rsp_valid_i) begin
                    if (!rsp_own_i)
                        c_d.st = ST_SUSP;
                    else if (len_zero_i)
                        c_d.st = ST_WAIT;
                    else begin
                        c_d.st     = ST_READ;
                        cnt_load_o = 1'b1;
                    end
                end
            end
            ST_READ: begin
                c_d.stop_pend = stop_now;
                if (underflow_i)
                    c_d.st = ST_SUSP;
                else if (mv_ack_i) begin
                    cnt_dec_o = 1'b1;
                    if (last_beat_i)
                        c_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                c_d.stop_pend = stop_now;
                if (underflow_i)
                    c_d.st = ST_SUSP;
                else if (status_i)
                    c_d.st = ST_CLOSE;
            end
            ST_CLOSE: begin
                idx_adv_o     = 1'b1;
                c_d.stop_pend = 1'b0;
                c_d.st        = stop_now ? ST_STOP : ST_FETCH;
            end
            ST_SUSP: begin
                if (stop_now) begin
                    c_d.st        = ST_STOP;
                    c_d.stop_pend = 1'b0;
                end else if (poll_i)
                    c_d.st = ST_FETCH;
            end
            default: begin
                c_d.st        = ST_STOP;
                c_d.stop_pend = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_STOP, stop_pend: 1'b0};
        else        c_q <= c_d;
    end

    assign st_o = c_q.st;

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.st inside {ST_STOP, ST_FETCH, ST_WAIT, ST_READ, ST_SUSP, ST_CLOSE}); // R2

    AST_READ_FROM_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_READ && $past(c_q.st) != ST_READ) |-> $past(c_q.st) == ST_FETCH); // R4

    AST_CLOSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_CLOSE) |=> c_q.st != ST_CLOSE); // R6

    AST_UNDERFLOW_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_i && (c_q.st == ST_READ || c_q.st == ST_WAIT)) |=> c_q.st == ST_SUSP); // R7

    AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_STOP && $past(c_q.st) != ST_STOP)
            |-> ($past(c_q.st) == ST_CLOSE || $past(c_q.st) == ST_SUSP)); // R9

    AST_PEND_STOP_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.stop_pend && c_q.st == ST_CLOSE) |=> c_q.st == ST_STOP); // R9

endmodule

// File: rtl/tx_desc_fsm.sv
module tx_desc_fsm
    import txd_pkg::*;
#(
    parameter int LEN_W      = 12,
    parameter int RING_DEPTH = 8,
    parameter int IDX_W      = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             desc_rsp_valid_i,
    input  logic             desc_rsp_own_i,
    input  logic [LEN_W-1:0] desc_rsp_len_i,
    input  logic             mv_ack_i,
    input  logic             underflow_i,
    input  logic             tx_status_i,
    input  logic             poll_i,
    output logic             desc_req_o,
    output logic             mv_req_o,
    output logic             wb_strobe_o,
    output logic [IDX_W-1:0] desc_idx_o,
    output logic [2:0]       state_o
);
    txd_state_e st;
    logic       cnt_load, cnt_dec, last_beat;
    logic       idx_clr, idx_adv;
    logic       len_zero;

    assign len_zero = (desc_rsp_len_i == '0);

    txd_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .rsp_valid_i (desc_rsp_valid_i),
        .rsp_own_i   (desc_rsp_own_i),
        .len_zero_i  (len_zero),
        .mv_ack_i    (mv_ack_i),
        .last_beat_i (last_beat),
        .underflow_i (underflow_i),
        .status_i    (tx_status_i),
        .poll_i      (poll_i),
        .st_o        (st),
        .cnt_load_o  (cnt_load),
        .cnt_dec_o   (cnt_dec),
        .idx_clr_o   (idx_clr),
        .idx_adv_o   (idx_adv)
    );

    txd_beat_cnt #(.LEN_W(LEN_W)) u_beats (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cnt_load),
        .len_i  (desc_rsp_len_i),
        .dec_i  (cnt_dec),
        .last_o (last_beat)
    );

    txd_ring_ptr #(.DEPTH(RING_DEPTH), .IDX_W(IDX_W)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (idx_clr),
        .adv_i (idx_adv),
        .idx_o (desc_idx_o)
    );

    assign state_o     = st;
    assign desc_req_o  = (st == ST_FETCH);
    assign mv_req_o    = (st == ST_READ);
    assign wb_strobe_o = (st == ST_CLOSE);

    AST_IDX_MOVES_AT_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_idx_o != $past(desc_idx_o))
            |-> ($past(st) == ST_CLOSE || $past(st) == ST_STOP)); // R8

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({desc_req_o, mv_req_o, wb_strobe_o})); // R2

endmodule

// File: tb/tb_tx_desc_fsm.sv
module tb_tx_desc_fsm;
    localparam int LEN_W = 12;
    localparam int DEPTH = 8;
    localparam int IDX_W = 3;

    localparam logic [2:0] S_STOP  = 3'b000;
    localparam logic [2:0] S_FETCH = 3'b001;
    localparam logic [2:0] S_WAIT  = 3'b010;
    localparam logic [2:0] S_READ  = 3'b011;
    localparam logic [2:0] S_SUSP  = 3'b110;
    localparam logic [2:0] S_CLOSE = 3'b111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, rsp_valid = 0, rsp_own = 0;
    logic [LEN_W-1:0] rsp_len = '0;
    logic mv_ack = 0, underflow = 0, status = 0, poll = 0;
    logic desc_req, mv_req, wb_strobe;
    logic [IDX_W-1:0] idx;
    logic [2:0] state;

    always #4 clk = ~clk;

    tx_desc_fsm #(.LEN_W(LEN_W), .RING_DEPTH(DEPTH), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .desc_rsp_valid_i(rsp_valid), .desc_rsp_own_i(rsp_own),
        .desc_rsp_len_i(rsp_len), .mv_ack_i(mv_ack), .underflow_i(underflow),
        .tx_status_i(status), .poll_i(poll), .desc_req_o(desc_req),
        .mv_req_o(mv_req), .wb_strobe_o(wb_strobe), .desc_idx_o(idx),
        .state_o(state)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [2:0] m_st = S_STOP;
    int m_idx = 0, m_cnt = 0;
    bit m_stp = 0;
    string m_tag = "R1";

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk(m_tag, "state", int'(state), int'(m_st));
        chk(m_tag, "index", int'(idx), m_idx);
        chk("R2", "strobes", int'({desc_req, mv_req, wb_strobe}),
            int'({m_st == S_FETCH, m_st == S_READ, m_st == S_CLOSE}));
    endtask

    function automatic void model(bit s, bit p, bit rv, bit own, int len,
                                  bit ack, bit uf, bit sv, bit pl);
        bit stop_now = m_stp || p;
        m_tag = "R2";
        case (m_st)
            S_STOP: begin
                m_stp = 0;
                if (s && !p) begin m_st = S_FETCH; m_idx = 0; m_tag = "R3"; end
                else if (p) m_tag = "R9";
                else m_tag = "R3";
            end
            S_FETCH: begin
                m_stp = stop_now; m_tag = "R4";
                if (rv) begin
                    if (!own) m_st = S_SUSP;
                    else if (len == 0) m_st = S_WAIT;
                    else begin m_st = S_READ; m_cnt = len; end
                end
            end
            S_READ: begin
                m_stp = stop_now; m_tag = "R5";
                if (uf) begin m_st = S_SUSP; m_tag = "R7"; end
                else if (ack) begin
                    m_cnt--;
                    if (m_cnt == 0) m_st = S_WAIT;
                end
            end
            S_WAIT: begin
                m_stp = stop_now; m_tag = "R6";
                if (uf) begin m_st = S_SUSP; m_tag = "R7"; end
                else if (sv) m_st = S_CLOSE;
            end
            S_CLOSE: begin
                m_idx = (m_idx + 1) % DEPTH;
                m_stp = 0;
                if (stop_now) begin m_st = S_STOP; m_tag = "R9"; end
                else begin m_st = S_FETCH; m_tag = "R6"; end
            end
            default: begin
                if (stop_now) begin m_st = S_STOP; m_stp = 0; m_tag = "R9"; end
                else begin
                    m_tag = "R8";
                    if (pl) m_st = S_FETCH;
                end
            end
        endcase
    endfunction

    task automatic step(bit s, bit p, bit rv, bit own, int len,
                        bit ack, bit uf, bit sv, bit pl);
        check_outputs();
        start_i = s; stop_i = p; rsp_valid = rv; rsp_own = own;
        rsp_len = LEN_W'(len); mv_ack = ack; underflow = uf;
        status = sv; poll = pl;
        model(s, p, rv, own, len, ack, uf, sv, pl);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        int sd;
        sd = $urandom(32'd2468);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, then stop ignored and stop beats start (R9)
        step(0, 1, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0, 0, 0);
        // R4 ignored response while stopped; R8 poll ignored
        step(0, 0, 1, 1, 2, 0, 0, 0, 1);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);           // R3
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);           // R8 poll ignored in fetch
        step(0, 0, 1, 1, 2, 0, 0, 0, 0);           // R4 -> read
        step(1, 0, 0, 0, 0, 1, 0, 0, 0);           // R3 start ignored, R5 beat
        step(0, 0, 0, 0, 0, 1, 1, 0, 0);           // R7 last beat vs underflow
        idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);           // R8 resume same index
        step(0, 0, 1, 1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0, 0, 0);           // R5 single beat
        step(0, 0, 0, 0, 0, 0, 1, 1, 0);           // R7 status vs underflow
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 1, 1, 0, 0, 0, 0, 0);           // R4 zero length -> wait
        step(0, 0, 0, 0, 0, 0, 0, 1, 0);           // R6 close
        step(0, 1, 0, 0, 0, 0, 0, 0, 0);           // R9 stop during close
        idle();
        // R6 ring wrap
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < DEPTH + 2; k++) begin
            step(0, 0, 1, 1, 0, 0, 0, 0, 0);
            step(0, 0, 0, 0, 0, 0, 0, 1, 0);
            idle();
        end
        // R9 pending stop from fetch, held through the descriptor
        step(0, 1, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 1, 1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0);
        idle(); idle();
        // R4 unowned -> suspended; R9 stop beats poll
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 3, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0, 0, 0, 1);
        idle();
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 6) == 0, ($urandom % 45) == 0,
                 ($urandom % 3) == 0, ($urandom % 4) != 0, int'($urandom % 4),
                 ($urandom % 2) == 0, ($urandom % 30) == 0,
                 ($urandom % 4) == 0, ($urandom % 6) == 0);
        end
        check_outputs();
        finish_up();
    end
endmodule